// File: doc/BRIEF.md
# Hotplug Slot Command Controller

This block keeps the control state of a bank of hot-pluggable card slots: a two-bit slot state, a power indicator, an attention indicator, a latch-open flag and a presence code for each slot. Software's command register write reaches the block as a one-cycle strobe carrying an 8-bit code and a 5-bit target. The block decodes that code as a single-slot command, a bus-speed selection or a command for all slots. It applies only the permitted state changes, reports the outcome in four command status bits and pulses a completion strobe when the command ends.

Single-slot and bus-speed commands finish on the clock edge that accepts them. The two all-slot commands first check every slot at once and then visit one slot per clock cycle, lowest index first, with the busy bit raised for the whole sweep. When a slot is taken to disabled and its power indicator then reads off, the block treats the card as gone. It pulses a per-slot removal request, marks the latch open and the slot empty, and sets three sticky event bits. An interrupt block downstream reads and clears those bits.

Top module: `slot_cmd_ctrl`

## Requirements
- R1: A synchronous reset puts every slot whose `slot_occupied_i` bit is 1 into state 2 (enabled) with power indicator 1 (on), latch closed and presence 0. Every other slot goes to state 3 (disabled) with power indicator 3 (off), latch open and presence 3 (empty). All attention indicators, event bits and command status bits reset to 0.
- R2: A code in 0x00..0x3F is a single-slot command. Bits [1:0] request a state (0 keep, 1 power-only, 2 enabled, 3 disabled), bits [3:2] give the power indicator and bits [5:4] give the attention indicator (0 keep, 1 on, 2 blink, 3 off). Each nonzero indicator field is written to the target slot.
- R3: The target is a logical slot number, where slot index i is target i+1. A target of 0, or one larger than NUM_SLOTS, sets invalid-command (status bit 2) and changes no slot.
- R4: A disabled slot may move to power-only or enabled. An enabled or power-only slot may move to disabled. Any other request leaves the state unchanged. Requesting power-only for an enabled slot sets invalid-command and leaves state and both indicators untouched.
- R5: If a move to disabled leaves the power indicator at 3, then `remove_req_o` for that slot pulses for exactly one cycle. In the same update the latch flag becomes open and the presence code becomes 3, and the slot's event bits [2] button, [1] latch and [0] presence are all set.
- R6: Codes 0x40..0x47 select a bus speed from bits [2:0]. Speed 0 is accepted, and any other speed sets invalid-mode (status bit 3).
- R7: Code 0x48 (power-only all) and code 0x49 (enable all) set invalid-command and change nothing if any slot is enabled.
- R8: Otherwise the all-slot command visits slot indices in order, one per cycle. A slot with a closed latch receives the requested state (1 for 0x48, 2 for 0x49) under the R4 rules, together with power indicator 1. A slot with an open latch receives power indicator 3 and keeps its state. Busy (status bit 0) is high for exactly NUM_SLOTS cycles, and strobes arriving while busy are ignored.
- R9: Accepting a command first clears status bits 0..3. Bit 1 (latch error) is never set. Codes 0x4A..0xFF set invalid-command.
- R10: `cmd_done_o` pulses for one cycle when each command finishes. It rises in the cycle after the accepting edge for non-sweep commands, and together with the fall of busy for sweeps.
- R11: Event bits stay set until a 1 is written to the matching `evt_clr_i` bit. A set and a clear of the same bit in the same cycle leave the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_occupied_i | input | NUM_SLOTS | Per-slot card present at reset |
| cmd_valid_i | input | 1 | One-cycle command strobe |
| cmd_code_i | input | 8 | Command code |
| cmd_target_i | input | 5 | Logical target slot (1-based) |
| evt_clr_i | input | 3*NUM_SLOTS | Write-one-to-clear for event bits, 3 per slot |
| slot_state_o | output | 2*NUM_SLOTS | Slot state, 2 bits per slot |
| slot_pwr_ind_o | output | 2*NUM_SLOTS | Power indicator, 2 bits per slot |
| slot_attn_ind_o | output | 2*NUM_SLOTS | Attention indicator, 2 bits per slot |
| slot_latch_open_o | output | NUM_SLOTS | Latch open flag per slot |
| slot_presence_o | output | 2*NUM_SLOTS | Presence code, 2 bits per slot |
| slot_evt_o | output | 3*NUM_SLOTS | Sticky events {button, latch, presence} per slot |
| remove_req_o | output | NUM_SLOTS | One-cycle removal request per slot |
| cmd_status_o | output | 4 | {invalid-mode, invalid-command, latch error, busy} |
| cmd_done_o | output | 1 | Command finished pulse |

## Verification
The assertions check properties that must hold in every cycle:
- a removal request always coincides with a slot that is disabled, empty, latch-open and power-off, and never lasts more than one cycle;
- the sweep index stays in range, and no sweep step is ever an illegal transition;
- the invalid flags stay clear while busy, and busy always falls together with the completion pulse;
- a command with a bad target never writes a slot.

Only the directed scenarios can show the decoded effect of specific codes and the pass-or-fail outcome of each transition. They also show the latch-dependent outcome of each sweep, the exact length of the busy window, the ignored mid-sweep strobe and the precedence between event set and clear.

// File: rtl/slot_cmd_pkg.sv
package slot_cmd_pkg;

    typedef enum logic [1:0] {
        ST_KEEP     = 2'd0,
        ST_PWRONLY  = 2'd1,
        ST_ENABLED  = 2'd2,
        ST_DISABLED = 2'd3
    } slot_state_e;

    typedef enum logic [1:0] {
        IND_KEEP  = 2'd0,
        IND_ON    = 2'd1,
        IND_BLINK = 2'd2,
        IND_OFF   = 2'd3
    } ind_e;

    typedef enum logic [2:0] {
        K_SLOT    = 3'd0,
        K_SPEED   = 3'd1,
        K_PWR_ALL = 3'd2,
        K_EN_ALL  = 3'd3,
        K_BAD     = 3'd4
    } cmd_kind_e;

    localparam logic [1:0] PRES_FULL  = 2'd0;
    localparam logic [1:0] PRES_EMPTY = 2'd3;

    localparam int STAT_BUSY    = 0;
    localparam int STAT_LATCH   = 1;
    localparam int STAT_BADCMD  = 2;
    localparam int STAT_BADMODE = 3;
    localparam int STAT_W       = 4;

    localparam int EVT_W       = 3;
    localparam int EVT_BUTTON  = 2;
    localparam int EVT_LATCH   = 1;
    localparam int EVT_PRESENT = 0;

    typedef struct packed {
        slot_state_e state;
        ind_e        pwr;
        ind_e        attn;
        logic        latch_open;
        logic [1:0]  presence;
    } slot_t;

    typedef struct packed {
        cmd_kind_e   kind;
        slot_state_e req_state;
        ind_e        pwr;
        ind_e        attn;
        logic [2:0]  speed;
    } cmd_t;

    typedef struct packed {
        slot_t nxt;
        logic  removed;
        logic  illegal;
    } slot_upd_t;

    function automatic cmd_t decode_cmd(input logic [7:0] code);
        cmd_t c;
        c.kind      = K_BAD;
        c.req_state = ST_KEEP;
        c.pwr       = IND_KEEP;
        c.attn      = IND_KEEP;
        c.speed     = 3'd0;
        if (code[7:6] == 2'b00) begin
            c.kind      = K_SLOT;
            c.req_state = slot_state_e'(code[1:0]);
            c.pwr       = ind_e'(code[3:2]);
            c.attn      = ind_e'(code[5:4]);
        end else if (code[7:3] == 5'b01000) begin
            c.kind  = K_SPEED;
            c.speed = code[2:0];
        end else if (code == 8'h48) begin
            c.kind = K_PWR_ALL;
        end else if (code == 8'h49) begin
            c.kind = K_EN_ALL;
        end
        return c;
    endfunction

    function automatic slot_upd_t slot_step(input slot_t cur, input slot_state_e req,
                                            input ind_e p, input ind_e a);
        slot_upd_t r;
        r.nxt     = cur;
        r.removed = 1'b0;
        r.illegal = 1'b0;
        if (cur.state == ST_ENABLED && req == ST_PWRONLY) begin
            r.illegal = 1'b1;
        end else begin
            if (p != IND_KEEP) r.nxt.pwr = p;
            if (a != IND_KEEP) r.nxt.attn = a;
            if (cur.state == ST_DISABLED && (req == ST_PWRONLY || req == ST_ENABLED)) begin
                r.nxt.state = req;
            end else if ((cur.state == ST_ENABLED || cur.state == ST_PWRONLY) &&
                         req == ST_DISABLED) begin
                r.nxt.state = ST_DISABLED;
                if (r.nxt.pwr == IND_OFF) begin
                    r.removed          = 1'b1;
                    r.nxt.latch_open   = 1'b1;
                    r.nxt.presence     = PRES_EMPTY;
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/slot_cmd_decode.sv
module slot_cmd_decode
    import slot_cmd_pkg::*;
(
    input  logic [7:0] code_i,
    output cmd_t       cmd_o
);
    always_comb cmd_o = decode_cmd(code_i);
endmodule

// File: rtl/slot_cmd_slot.sv
module slot_cmd_slot
    import slot_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             occupied_i,
    input  logic             wr_i,
    input  slot_upd_t        upd_i,
    input  logic [EVT_W-1:0] evt_clr_i,
    output slot_t            slot_o,
    output logic [EVT_W-1:0] evt_o,
    output logic             remove_o
);
    slot_t            s_q;
    logic [EVT_W-1:0] evt_q;
    logic             rm_q;
    logic [EVT_W-1:0] evt_set;

    assign evt_set = (wr_i && upd_i.removed) ? {EVT_W{1'b1}} : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            if (occupied_i) begin
                s_q <= '{state: ST_ENABLED, pwr: IND_ON, attn: IND_KEEP,
                         latch_open: 1'b0, presence: PRES_FULL};
            end else begin
                s_q <= '{state: ST_DISABLED, pwr: IND_OFF, attn: IND_KEEP,
                         latch_open: 1'b1, presence: PRES_EMPTY};
            end
            evt_q <= '0;
            rm_q  <= 1'b0;
        end else begin
            if (wr_i) s_q <= upd_i.nxt;
            rm_q  <= wr_i && upd_i.removed;
            evt_q <= (evt_q & ~evt_clr_i) | evt_set;
        end
    end

    assign slot_o   = s_q;
    assign evt_o    = evt_q;
    assign remove_o = rm_q;

    p_remove_state_r5: assert property (@(posedge clk) disable iff (rst)
        rm_q |-> (s_q.state == ST_DISABLED && s_q.pwr == IND_OFF &&
                  s_q.latch_open && s_q.presence == PRES_EMPTY && (&evt_q)));

    p_remove_single_r5: assert property (@(posedge clk) disable iff (rst)
        rm_q |=> !rm_q);
endmodule

// File: rtl/slot_cmd_seq.sv
module slot_cmd_seq
    import slot_cmd_pkg::*;
#(
    parameter int NUM_SLOTS = 31,
    parameter int IDX_W     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid_i,
    input  cmd_t              cmd_i,
    input  logic              target_ok_i,
    input  logic              any_enabled_i,
    input  logic              step_illegal_i,
    input  logic              idx_latch_open_i,
    output logic              apply_en_o,
    output slot_state_e       apply_state_o,
    output ind_e              apply_pwr_o,
    output ind_e              apply_attn_o,
    output logic              sweep_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [STAT_W-1:0] status_o,
    output logic              done_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

    typedef enum logic {F_IDLE, F_SWEEP} fsm_e;

    fsm_e             fsm_q;
    logic [IDX_W-1:0] idx_q;
    slot_state_e      mode_q;
    logic             busy_q, bad_cmd_q, bad_mode_q, latch_err_q, done_q;
    logic             accept;

    assign accept  = (fsm_q == F_IDLE) && cmd_valid_i;
    assign sweep_o = (fsm_q == F_SWEEP);
    assign idx_o   = idx_q;

    always_comb begin
        apply_en_o    = 1'b0;
        apply_state_o = cmd_i.req_state;
        apply_pwr_o   = cmd_i.pwr;
        apply_attn_o  = cmd_i.attn;
        if (fsm_q == F_SWEEP) begin
            apply_en_o   = 1'b1;
            apply_attn_o = IND_KEEP;
            if (idx_latch_open_i) begin
                apply_state_o = ST_KEEP;
                apply_pwr_o   = IND_OFF;
            end else begin
                apply_state_o = mode_q;
                apply_pwr_o   = IND_ON;
            end
        end else if (accept && cmd_i.kind == K_SLOT) begin
            apply_en_o = target_ok_i && !step_illegal_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q       <= F_IDLE;
            idx_q       <= '0;
            mode_q      <= ST_KEEP;
            busy_q      <= 1'b0;
            bad_cmd_q   <= 1'b0;
            bad_mode_q  <= 1'b0;
            latch_err_q <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (fsm_q == F_IDLE) begin
                if (cmd_valid_i) begin
                    busy_q      <= 1'b0;
                    bad_cmd_q   <= 1'b0;
                    bad_mode_q  <= 1'b0;
                    latch_err_q <= 1'b0;
                    unique case (cmd_i.kind)
                        K_SLOT: begin
                            if (!target_ok_i || step_illegal_i) bad_cmd_q <= 1'b1;
                            done_q <= 1'b1;
                        end
                        K_SPEED: begin
                            if (cmd_i.speed != 3'd0) bad_mode_q <= 1'b1;
                            done_q <= 1'b1;
                        end
                        K_PWR_ALL, K_EN_ALL: begin
                            if (any_enabled_i) begin
                                bad_cmd_q <= 1'b1;
                                done_q    <= 1'b1;
                            end else begin
                                busy_q <= 1'b1;
                                fsm_q  <= F_SWEEP;
                                idx_q  <= '0;
                                mode_q <= (cmd_i.kind == K_EN_ALL) ? ST_ENABLED : ST_PWRONLY;
                            end
                        end
                        default: begin
                            bad_cmd_q <= 1'b1;
                            done_q    <= 1'b1;
                        end
                    endcase
                end
            end else begin
                if (idx_q == LAST_IDX) begin
                    fsm_q  <= F_IDLE;
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    idx_q  <= '0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        status_o               = '0;
        status_o[STAT_BUSY]    = busy_q;
        status_o[STAT_LATCH]   = latch_err_q;
        status_o[STAT_BADCMD]  = bad_cmd_q;
        status_o[STAT_BADMODE] = bad_mode_q;
    end
    assign done_o = done_q;

    p_busy_flags_clear_r7: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (!bad_cmd_q && !bad_mode_q));

    p_done_with_busy_fall_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> done_q);

    p_idx_bound_r8: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (idx_q <= LAST_IDX));
endmodule

// File: rtl/slot_cmd_ctrl.sv
module slot_cmd_ctrl
    import slot_cmd_pkg::*;
#(
    parameter int NUM_SLOTS = 31
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SLOTS-1:0]       slot_occupied_i,
    input  logic                       cmd_valid_i,
    input  logic [7:0]                 cmd_code_i,
    input  logic [4:0]                 cmd_target_i,
    input  logic [EVT_W*NUM_SLOTS-1:0] evt_clr_i,
    output logic [2*NUM_SLOTS-1:0]     slot_state_o,
    output logic [2*NUM_SLOTS-1:0]     slot_pwr_ind_o,
    output logic [2*NUM_SLOTS-1:0]     slot_attn_ind_o,
    output logic [NUM_SLOTS-1:0]       slot_latch_open_o,
    output logic [2*NUM_SLOTS-1:0]     slot_presence_o,
    output logic [EVT_W*NUM_SLOTS-1:0] slot_evt_o,
    output logic [NUM_SLOTS-1:0]       remove_req_o,
    output logic [STAT_W-1:0]          cmd_status_o,
    output logic                       cmd_done_o
);
    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    cmd_t             dec;
    slot_t            slots [NUM_SLOTS];
    slot_t            cur;
    slot_upd_t        upd;
    logic             target_ok, any_enabled, apply_en, sweep;
    logic [4:0]       tgt_m1;
    logic [IDX_W-1:0] sel, idx;
    slot_state_e      ap_state;
    ind_e             ap_pwr, ap_attn;

    slot_cmd_decode u_dec (.code_i(cmd_code_i), .cmd_o(dec));

    assign target_ok = (cmd_target_i != 5'd0) && (int'(cmd_target_i) <= NUM_SLOTS);
    assign tgt_m1    = cmd_target_i - 5'd1;
    assign sel       = sweep ? idx : tgt_m1[IDX_W-1:0];

    always_comb begin
        any_enabled = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++)
            if (slots[i].state == ST_ENABLED) any_enabled = 1'b1;
    end

    always_comb cur = (int'(sel) < NUM_SLOTS) ? slots[sel] : '0;
    always_comb upd = slot_step(cur, ap_state, ap_pwr, ap_attn);

    slot_cmd_seq #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_seq (
        .clk              (clk),
        .rst              (rst),
        .cmd_valid_i      (cmd_valid_i),
        .cmd_i            (dec),
        .target_ok_i      (target_ok),
        .any_enabled_i    (any_enabled),
        .step_illegal_i   (upd.illegal),
        .idx_latch_open_i (cur.latch_open),
        .apply_en_o       (apply_en),
        .apply_state_o    (ap_state),
        .apply_pwr_o      (ap_pwr),
        .apply_attn_o     (ap_attn),
        .sweep_o          (sweep),
        .idx_o            (idx),
        .status_o         (cmd_status_o),
        .done_o           (cmd_done_o)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic wr;
        assign wr = apply_en && (int'(sel) == g);
        slot_cmd_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .occupied_i (slot_occupied_i[g]),
            .wr_i       (wr),
            .upd_i      (upd),
            .evt_clr_i  (evt_clr_i[EVT_W*g +: EVT_W]),
            .slot_o     (slots[g]),
            .evt_o      (slot_evt_o[EVT_W*g +: EVT_W]),
            .remove_o   (remove_req_o[g])
        );
        assign slot_state_o[2*g +: 2]    = slots[g].state;
        assign slot_pwr_ind_o[2*g +: 2]  = slots[g].pwr;
        assign slot_attn_ind_o[2*g +: 2] = slots[g].attn;
        assign slot_latch_open_o[g]      = slots[g].latch_open;
        assign slot_presence_o[2*g +: 2] = slots[g].presence;
    end

    p_sweep_legal_r8: assert property (@(posedge clk) disable iff (rst)
        sweep |-> !upd.illegal);

    p_bad_target_nowrite_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_i && !sweep && dec.kind == K_SLOT && !target_ok) |-> !apply_en);
endmodule

// File: tb/slot_cmd_ctrl_tb_top.sv
module slot_cmd_ctrl_tb_top;
    localparam int N        = 6;
    localparam int CLK_PER  = 10;
    localparam int WATCHDOG = 20000;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   occ = 6'b001011;
    logic           cmd_valid = 1'b0;
    logic [7:0]     cmd_code = '0;
    logic [4:0]     cmd_target = '0;
    logic [3*N-1:0] evt_clr = '0;
    logic [2*N-1:0] st_o, pwr_o, attn_o, pres_o;
    logic [N-1:0]   lat_o, rm_o;
    logic [3*N-1:0] evt_o;
    logic [3:0]     stat_o;
    logic           done_o;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PER/2) clk = ~clk;

    slot_cmd_ctrl #(.NUM_SLOTS(N)) dut_i (
        .clk(clk), .rst(rst), .slot_occupied_i(occ),
        .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code), .cmd_target_i(cmd_target),
        .evt_clr_i(evt_clr),
        .slot_state_o(st_o), .slot_pwr_ind_o(pwr_o), .slot_attn_ind_o(attn_o),
        .slot_latch_open_o(lat_o), .slot_presence_o(pres_o), .slot_evt_o(evt_o),
        .remove_req_o(rm_o), .cmd_status_o(stat_o), .cmd_done_o(done_o)
    );

    function automatic int st(int i);   return int'(st_o[2*i +: 2]);   endfunction
    function automatic int pw(int i);   return int'(pwr_o[2*i +: 2]);  endfunction
    function automatic int at(int i);   return int'(attn_o[2*i +: 2]); endfunction
    function automatic int pr(int i);   return int'(pres_o[2*i +: 2]); endfunction
    function automatic int ev(int i);   return int'(evt_o[3*i +: 3]);  endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive at a negedge; return at the next negedge with results visible.
    task automatic issue(input logic [7:0] c, input logic [4:0] t);
        cmd_code = c; cmd_target = t; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 slot0 state", st(0), 2);
        check("R1 slot0 pwr", pw(0), 1);
        check("R1 slot0 latch", int'(lat_o[0]), 0);
        check("R1 slot0 presence", pr(0), 0);
        check("R1 slot2 state", st(2), 3);
        check("R1 slot2 pwr", pw(2), 3);
        check("R1 slot2 latch", int'(lat_o[2]), 1);
        check("R1 slot2 presence", pr(2), 3);
        check("R1 attn", int'(attn_o), 0);
        check("R1 status", int'(stat_o), 0);
        check("R1 events", int'(evt_o), 0);
    endtask

    task automatic t_fields;
        issue(8'h20, 5'd1);              // attention blink only
        check("R2 attn blink", at(0), 2);
        check("R2 pwr kept", pw(0), 1);
        check("R2 state kept", st(0), 2);
        check("R10 done single", int'(done_o), 1);
        @(negedge clk);
        check("R10 done one cycle", int'(done_o), 0);
    endtask

    task automatic t_illegal;
        issue(8'h0D, 5'd1);              // power-only + pwr off on enabled slot
        check("R4 illegal status", int'(stat_o), 4);
        check("R4 illegal pwr kept", pw(0), 1);
        check("R4 illegal state kept", st(0), 2);
    endtask

    task automatic t_target;
        issue(8'h03, 5'd0);
        check("R3 target zero", int'(stat_o), 4);
        issue(8'h1C, 5'd7);
        check("R3 target high status", int'(stat_o), 4);
        check("R3 target high no write", pw(5), 3);
        check("R3 target high attn", at(5), 0);
        issue(8'h10, 5'd1);
        check("R9 status cleared", int'(stat_o), 0);
        check("R3 target one attn", at(0), 1);
    endtask

    task automatic t_remove;
        issue(8'h0F, 5'd2);              // disable + pwr off on slot1
        check("R5 state", st(1), 3);
        check("R5 pwr", pw(1), 3);
        check("R5 remove pulse", int'(rm_o), 6'b000010);
        check("R5 latch", int'(lat_o[1]), 1);
        check("R5 presence", pr(1), 3);
        check("R5 events", ev(1), 7);
        @(negedge clk);
        check("R5 pulse ends", int'(rm_o), 0);
        issue(8'h0B, 5'd4);              // disable + pwr blink on slot3
        check("R4 disable ok", st(3), 3);
        check("R5 no remove", int'(rm_o), 0);
        check("R5 latch closed", int'(lat_o[3]), 0);
        check("R5 presence kept", pr(3), 0);
    endtask

    task automatic t_events;
        evt_clr = '0; evt_clr[3*1 + 1] = 1'b1;
        @(negedge clk);
        evt_clr = '0;
        check("R11 partial clear", ev(1), 5);
        @(negedge clk);
        check("R11 sticky", ev(1), 5);
    endtask

    task automatic t_speed;
        issue(8'h40, 5'd0);
        check("R6 speed zero", int'(stat_o), 0);
        issue(8'h45, 5'd0);
        check("R6 speed bad", int'(stat_o), 8);
        issue(8'h4A, 5'd0);
        check("R9 code 4A", int'(stat_o), 4);
        issue(8'h40, 5'd0);
        check("R9 clear after", int'(stat_o), 0);
        issue(8'hFF, 5'd0);
        check("R9 code FF", int'(stat_o), 4);
    endtask

    task automatic t_all_blocked;
        issue(8'h48, 5'd0);              // slot0 still enabled
        check("R7 status", int'(stat_o), 4);
        check("R7 slot3 kept", st(3), 3);
        check("R7 slot2 pwr", pw(2), 3);
        check("R10 done on reject", int'(done_o), 1);
    endtask

    task automatic t_sweep;
        int cyc;
        issue(8'h0F, 5'd1);              // remove slot0
        check("R5 slot0 removed", int'(lat_o[0]), 1);
        issue(8'h49, 5'd0);
        check("R8 busy", int'(stat_o), 1);
        cmd_code = 8'h30; cmd_target = 5'd4; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 1;
        while (stat_o[0] && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        check("R8 busy length", cyc, N);
        check("R10 done at end", int'(done_o), 1);
        check("R8 closed slot enabled", st(3), 2);
        check("R8 closed slot pwr on", pw(3), 1);
        check("R8 ignored while busy", at(3), 0);
        check("R8 open slot pwr off", pw(0), 3);
        check("R8 open slot state", st(2), 3);
        check("R8 status end", int'(stat_o), 0);
        issue(8'h0B, 5'd4);
        issue(8'h48, 5'd0);
        repeat (N) @(negedge clk);
        check("R8 power-only state", st(3), 1);
        check("R8 power-only pwr", pw(3), 1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_fields;
        t_illegal;
        t_target;
        t_remove;
        t_events;
        t_speed;
        t_all_blocked;
        t_sweep;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule